// File: doc/BRIEF.md
# Oversampled data recovery unit

This block recovers a serial bit stream that was captured with four samples per bit by a receive clock that runs free of the transmitter. The receive clock runs at half the bit rate, so every cycle the block takes one 8-sample word spanning two bit periods. It marks every transition between neighbouring samples, folds those marks onto the four sample phases of a bit, and sums them over a fixed window of cycles. At the end of each window a voter picks the phase lying half a bit away from the busiest edge phase. The chosen sampling phase then moves one step toward that target.

The two clocks may differ by up to ±100 ppm, so the best phase creeps slowly. When the chosen phase steps across the boundary between words, one bit would be sampled twice or one would be lost. The block covers this by emitting one bit or three bits in that cycle instead of the usual two. Each cycle it registers up to three recovered bits and a count of how many are valid. A downstream deserializer packs them.

Top module: `oversample_dru`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `bits_cnt` is 0 and `bits_out` is 0. Reset clears the edge sums, clears the stored last sample and sets the sampling phase to 2.
- R2: `samp_in[i]` is the i-th sample in time order. Samples 0..3 cover the earlier bit of the cycle and samples 4..7 cover the later bit. Sampling phase p reads samples p and p+4.
- R3: Outputs are registered and describe the word captured at the same clock edge. In a cycle without a wrap, `bits_cnt` is 2 and `bits_out` is {0, samp_in[p], samp_in[p+4]}. Bit 1 is the earlier bit in time.
- R4: An edge is counted at position k when sample k differs from sample k-1. Position 0 is compared with sample 7 of the previous cycle. Edges at k and k+4 are summed into phase k mod 4. A window is WIN_CYC cycles long and starts with the first cycle after reset. The decision taken on a window's last cycle already governs that cycle's output.
- R5: The target phase is (busiest edge phase + 2) mod 4, and ties go to the lowest phase. The phase steps +1 or −1 mod 4 toward the target. It holds when it already equals the target, or when the target lies two steps away.
- R6: A window that saw no edges at all leaves the phase unchanged.
- R7: A step from phase 3 to phase 0 emits one bit in that cycle: `bits_cnt` is 1 and `bits_out` is {0, 0, samp_in[4]}.
- R8: A step from phase 0 to phase 3 emits three bits in that cycle: `bits_cnt` is 3 and `bits_out` is {previous cycle's samp_in[7], samp_in[3], samp_in[7]}.
- R9: With the transmit bit period longer or shorter than four samples by one sample every 1024 samples, the emitted bit stream equals the transmitted stream without gaps or repeats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_in | input | 8 | Eight samples of this cycle, bit 0 earliest |
| bits_out | output | 3 | Recovered bits, higher index earlier in time |
| bits_cnt | output | 2 | Number of valid bits in `bits_out` (1 to 3) |

## Verification
Every result of this block is due one clock edge after the word that causes it: the bits, the count and the effect of a window decision all appear in the output registered at the edge that captures the window's last word. The bench drives each word at a falling edge and reads the outputs one nanosecond after the next rising edge, so each read sees exactly the word just captured. Window boundaries are known by counting words from the release of reset, so directed tests place decisions and phase probes on exact cycles. The drifting-stream test aligns the received stream to the transmitted one once and then compares every bit.

// File: rtl/dru_pkg.sv
`timescale 1ns/1ps
package dru_pkg;
  localparam int unsigned SPB = 4;                 // samples per bit
  localparam int unsigned BPW = 2;                 // bits per sampled word
  localparam int unsigned SPW = SPB * BPW;         // samples per word
  localparam int unsigned PHW = $clog2(SPB);
  localparam int unsigned SIW = $clog2(SPW);

  typedef logic [PHW-1:0] phase_t;
  typedef logic [SIW-1:0] sidx_t;
  localparam phase_t PH_RESET = phase_t'(SPB / 2);

  typedef enum logic [1:0] {STEP_HOLD = 2'd0, STEP_FWD = 2'd1, STEP_BACK = 2'd2} step_e;

  typedef struct packed {
    logic [2:0] bits;
    logic [1:0] cnt;
  } emit_t;

  // transition marks; position 0 looks back at the last sample of the prior word
  function automatic logic [SPW-1:0] edge_vec(input logic prev_last, input logic [SPW-1:0] s);
    return s ^ {s[SPW-2:0], prev_last};
  endfunction

  // sampling point half a bit away from the busiest edge phase
  function automatic phase_t aim_phase(input phase_t busiest);
    return busiest + phase_t'(SPB / 2);
  endfunction

  function automatic step_e step_toward(input phase_t cur, input phase_t tgt);
    phase_t d;
    d = tgt - cur;
    if (d == phase_t'(1))            return STEP_FWD;
    else if (d == phase_t'(SPB - 1)) return STEP_BACK;
    else                             return STEP_HOLD;
  endfunction

  function automatic emit_t pick_bits(input phase_t ph, input logic [SPW-1:0] s,
                                      input logic prev_last, input logic up, input logic dn);
    emit_t r;
    sidx_t ie, il;
    ie = sidx_t'(ph);
    il = sidx_t'(ph) + sidx_t'(SPB);
    if (up) begin
      r.bits = {2'b00, s[il]};
      r.cnt  = 2'd1;
    end else if (dn) begin
      r.bits = {prev_last, s[ie], s[il]};
      r.cnt  = 2'd3;
    end else begin
      r.bits = {1'b0, s[ie], s[il]};
      r.cnt  = 2'd2;
    end
    return r;
  endfunction
endpackage

// File: rtl/dru_edge_acc.sv
`timescale 1ns/1ps
module dru_edge_acc
  import dru_pkg::*;
#(
  parameter int unsigned WIN_CYC = 16,
  parameter int unsigned CW      = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SPW-1:0]          samp,
  output logic                    prev_last,
  output logic [SPB-1:0][CW-1:0]  tot,
  output logic                    dec_stb
);
  localparam int unsigned WW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CYC - 1);
  localparam logic [CW-1:0] ACC_MAX  = CW'(2 * (WIN_CYC - 1));

  logic [SPB-1:0][CW-1:0] acc_q;
  logic [WW-1:0]          win_q;
  logic [SPW-1:0]         edg;

  assign edg     = edge_vec(prev_last, samp);
  assign dec_stb = (win_q == WIN_LAST);

  for (genvar k = 0; k < SPB; k++) begin : g_ph
    assign tot[k] = acc_q[k] + CW'(edg[k]) + CW'(edg[k + SPB]);

    always_ff @(posedge clk) begin
      if (rst)          acc_q[k] <= '0;
      else if (dec_stb) acc_q[k] <= '0;
      else              acc_q[k] <= tot[k];
    end

    // R4: a running sum never exceeds two marks per cycle of a window
    a_r4_acc_bound: assert property (@(posedge clk) disable iff (rst)
      acc_q[k] <= ACC_MAX);
    // R4: a new window starts from empty sums
    a_r4_fresh_window: assert property (@(posedge clk) disable iff (rst)
      dec_stb |=> (acc_q[k] == '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q     <= '0;
      prev_last <= 1'b0;
    end else begin
      win_q     <= dec_stb ? '0 : win_q + WW'(1);
      prev_last <= samp[SPW-1];
    end
  end

  if (WIN_CYC > 1) begin : g_spacing
    // R4: decisions are at least one window apart
    a_r4_strobe_gap: assert property (@(posedge clk) disable iff (rst)
      dec_stb |=> !dec_stb);
  end
endmodule

// File: rtl/dru_phase_vote.sv
`timescale 1ns/1ps
module dru_phase_vote
  import dru_pkg::*;
#(
  parameter int unsigned CW = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SPB-1:0][CW-1:0]  tot,
  input  logic                    dec_stb,
  output phase_t                  ph_next,
  output logic                    wrap_up,
  output logic                    wrap_dn
);
  phase_t ph_q;
  phase_t busy;
  logic   any_edge;
  step_e  kind;

  always_comb begin
    busy = '0;
    for (int unsigned k = 1; k < SPB; k++) begin
      if (tot[k] > tot[busy]) busy = phase_t'(k);
    end
  end

  assign any_edge = |tot;
  assign kind     = (dec_stb && any_edge) ? step_toward(ph_q, aim_phase(busy)) : STEP_HOLD;

  always_comb begin
    unique case (kind)
      STEP_FWD:  ph_next = ph_q + phase_t'(1);
      STEP_BACK: ph_next = ph_q - phase_t'(1);
      default:   ph_next = ph_q;
    endcase
  end

  assign wrap_up = (kind == STEP_FWD)  && (ph_q == phase_t'(SPB - 1));
  assign wrap_dn = (kind == STEP_BACK) && (ph_q == '0);

  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_RESET;
    else     ph_q <= ph_next;
  end

  // R1: reset lands on the mid-bit phase
  a_r1_phase_reset: assert property (@(posedge clk)
    rst |=> (ph_q == PH_RESET));
  // R5: the phase moves by one position at most
  a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(ph_q) |-> ((ph_q == $past(ph_q) + phase_t'(1)) || (ph_q == $past(ph_q) - phase_t'(1))));
  // R5: the phase moves only on a window decision
  a_r5_move_on_decision: assert property (@(posedge clk) disable iff (rst)
    !$stable(ph_q) |-> $past(dec_stb));
  // R6: a window without edges keeps the phase
  a_r6_quiet_hold: assert property (@(posedge clk) disable iff (rst)
    (dec_stb && (tot == '0)) |=> $stable(ph_q));
  // R7, R8: a cycle cannot wrap both ways
  a_r8_wrap_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(wrap_up && wrap_dn));
endmodule

// File: rtl/dru_bit_emit.sv
`timescale 1ns/1ps
module dru_bit_emit
  import dru_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [SPW-1:0]  samp,
  input  logic            prev_last,
  input  phase_t          ph_sel,
  input  logic            wrap_up,
  input  logic            wrap_dn,
  output logic [2:0]      bits_out,
  output logic [1:0]      bits_cnt
);
  emit_t nxt;

  assign nxt = pick_bits(ph_sel, samp, prev_last, wrap_up, wrap_dn);

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_out <= '0;
      bits_cnt <= '0;
    end else begin
      bits_out <= nxt.bits;
      bits_cnt <= nxt.cnt;
    end
  end

  // R1: outputs are empty out of reset
  a_r1_empty_after_reset: assert property (@(posedge clk)
    rst |=> ((bits_cnt == 2'd0) && (bits_out == 3'd0)));
  // R3: two bits in an ordinary cycle
  a_r3_two_bits: assert property (@(posedge clk) disable iff (rst)
    (!wrap_up && !wrap_dn) |=> (bits_cnt == 2'd2) && !bits_out[2]);
  // R7: a forward wrap yields a lone bit in the lowest position
  a_r7_lone_bit: assert property (@(posedge clk) disable iff (rst)
    wrap_up |=> (bits_cnt == 2'd1) && (bits_out[2:1] == 2'b00));
  // R8: a backward wrap yields three bits
  a_r8_three_bits: assert property (@(posedge clk) disable iff (rst)
    wrap_dn |=> (bits_cnt == 2'd3));
endmodule

// File: rtl/oversample_dru.sv
`timescale 1ns/1ps
module oversample_dru
  import dru_pkg::*;
#(
  parameter int unsigned WIN_CYC = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [7:0]      samp_in,
  output logic [2:0]      bits_out,
  output logic [1:0]      bits_cnt
);
  localparam int unsigned CW = $clog2(2 * WIN_CYC + 1);

  logic                   prev_last;
  logic [SPB-1:0][CW-1:0] tot;
  logic                   dec_stb;
  phase_t                 ph_next;
  logic                   wrap_up;
  logic                   wrap_dn;

  dru_edge_acc #(.WIN_CYC(WIN_CYC), .CW(CW)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .samp      (samp_in),
    .prev_last (prev_last),
    .tot       (tot),
    .dec_stb   (dec_stb)
  );

  dru_phase_vote #(.CW(CW)) u_vote (
    .clk     (clk),
    .rst     (rst),
    .tot     (tot),
    .dec_stb (dec_stb),
    .ph_next (ph_next),
    .wrap_up (wrap_up),
    .wrap_dn (wrap_dn)
  );

  dru_bit_emit u_emit (
    .clk       (clk),
    .rst       (rst),
    .samp      (samp_in),
    .prev_last (prev_last),
    .ph_sel    (ph_next),
    .wrap_up   (wrap_up),
    .wrap_dn   (wrap_dn),
    .bits_out  (bits_out),
    .bits_cnt  (bits_cnt)
  );
endmodule

// File: tb/oversample_dru_tb_top.sv
`timescale 1ns/1ps
module oversample_dru_tb_top;
  localparam int TXN   = 20000;
  localparam int SHIFT = 1024;   // samples between one-sample slips
  localparam int SEG   = 4096;   // cycles per drift direction

  // {early, late, expected bits}
  localparam logic [4:0] TBL [16] = '{
    5'b01001, 5'b10010, 5'b11011, 5'b00000, 5'b10010, 5'b10010, 5'b01001, 5'b11011,
    5'b00000, 5'b01001, 5'b00000, 5'b11011, 5'b10010, 5'b01001, 5'b11011, 5'b00000};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] samp_in = '0;
  logic [2:0] bits_out;
  logic [1:0] bits_cnt;

  int n_chk = 0;
  int n_fail = 0;

  logic tx_mem [TXN];
  logic rx_mem [TXN];
  int   rx_n = 0;

  always #2.5 clk = ~clk;

  oversample_dru #(.WIN_CYC(16)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .samp_in  (samp_in),
    .bits_out (bits_out),
    .bits_cnt (bits_cnt)
  );

  task automatic expect_out(input string req, input logic [2:0] eb, input logic [1:0] ec);
    n_chk++;
    if (bits_out !== eb || bits_cnt !== ec) begin
      n_fail++;
      $display("FAIL %s: bits=%b cnt=%0d, expected bits=%b cnt=%0d", req, bits_out, bits_cnt, eb, ec);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    samp_in = '0;
    repeat (3) @(posedge clk);
    #1;
    expect_out("R1 reset", 3'b000, 2'd0);
  endtask

  // one word per cycle; outputs read 1 ns after the capturing edge
  task automatic cyc(input logic [7:0] w, input logic chk, input logic [2:0] eb,
                     input logic [1:0] ec, input string req);
    @(negedge clk);
    rst = 1'b0;
    samp_in = w;
    @(posedge clk);
    #1;
    if (chk) expect_out(req, eb, ec);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int pos, acc, step_slip, n1_slow, n3_fast, base, t;
    logic [7:0] w;
    logic found, ok;

    // R1 reset, then R2/R3 table walk at phase 2 with bit-aligned words
    do_reset();
    for (int i = 0; i < 16; i++) begin
      w = {{4{TBL[i][3]}}, {4{TBL[i][4]}}};
      cyc(w, 1'b1, TBL[i][2:0], 2'd2, "R2 R3 table");
    end

    // R5: edges at phase 2 put the target two steps away -> hold; probe phase 2
    do_reset();
    for (int i = 0; i < 16; i++) cyc(8'h3C, 1'b1, 3'b010, 2'd2, "R5 opposite hold");
    cyc(8'h04, 1'b1, 3'b010, 2'd2, "R5 probe phase 2");

    // R6: move to phase 3, then a quiet window, then probe phase 3
    do_reset();
    for (int i = 0; i < 16; i++) cyc(8'hE1, 1'b0, 3'b000, 2'd0, "");
    for (int i = 0; i < 16; i++) cyc(8'hFF, 1'b1, 3'b011, 2'd2, "R6 quiet at phase 3");
    cyc(8'h08, 1'b1, 3'b010, 2'd2, "R6 probe phase 3");

    // R4/R5/R7/R8: step 2->3, wrap 3->0, wrap 0->3
    do_reset();
    for (int i = 0; i < 16; i++) cyc(8'hE1, 1'b1, 3'b001, 2'd2, "R4 R5 step to phase 3");
    for (int i = 0; i < 15; i++) cyc(8'h3C, 1'b1, 3'b010, 2'd2, "R4 phase 3 hold in window");
    cyc(8'h3C, 1'b1, 3'b001, 2'd1, "R7 forward wrap");
    for (int i = 0; i < 15; i++) cyc(8'hE1, 1'b1, 3'b010, 2'd2, "R4 phase 0 in window");
    cyc(8'hE1, 1'b1, 3'b101, 2'd3, "R8 backward wrap");

    // R9: random stream, transmitter fast then slow by one sample per SHIFT
    do_reset();
    for (int i = 0; i < TXN; i++) tx_mem[i] = 1'($urandom_range(1, 0));
    pos = 1;
    acc = 0;
    n1_slow = 0;
    n3_fast = 0;
    for (int c = 0; c < 2 * SEG; c++) begin
      step_slip = (c < SEG) ? 2 : 0;
      for (int i = 0; i < 8; i++) begin
        w[i] = tx_mem[pos >> 2];
        acc++;
        if (acc == SHIFT) begin
          acc = 0;
          pos += step_slip;
        end else begin
          pos += 1;
        end
      end
      cyc(w, 1'b0, 3'b000, 2'd0, "");
      if (bits_cnt == 2'd3 && c < SEG) n3_fast++;
      if (bits_cnt == 2'd1 && c >= SEG) n1_slow++;
      for (int b = int'(bits_cnt) - 1; b >= 0; b--) begin
        if (rx_n < TXN) begin
          rx_mem[rx_n] = bits_out[b];
          rx_n++;
        end
      end
    end

    n_chk++;
    if (n3_fast == 0) begin
      n_fail++;
      $display("FAIL R8 drift: three-bit cycles=%0d, expected more than 0", n3_fast);
    end
    n_chk++;
    if (n1_slow == 0) begin
      n_fail++;
      $display("FAIL R7 drift: one-bit cycles=%0d, expected more than 0", n1_slow);
    end

    found = 1'b0;
    base = 0;
    for (int j = 0; j < 64 && !found; j++) begin
      ok = 1'b1;
      for (int k = 0; k < 64; k++) if (rx_mem[8 + k] !== tx_mem[j + k]) ok = 1'b0;
      if (ok) begin
        found = 1'b1;
        base = j;
      end
    end
    n_chk++;
    if (!found) begin
      n_fail++;
      $display("FAIL R9 lock: alignment found=0, expected 1");
    end else begin
      for (int k = 8; k < rx_n; k++) begin
        t = base + k - 8;
        if (t < TXN) begin
          n_chk++;
          if (rx_mem[k] !== tx_mem[t]) begin
            n_fail++;
            $display("FAIL R9 stream bit %0d: got %b, expected %b", k, rx_mem[k], tx_mem[t]);
          end
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule